// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block sits beside a UART core and handles the modem handshake lines. A byte-wide control register drives four modem outputs (DTR, RTS and two general outputs) and selects a loopback mode. A byte-wide status register shows the current levels of the four modem inputs (CTS, DSR, RI, DCD). It also holds four change flags that record any change of those inputs since software last read the register. Reading the status register clears the change flags. A single interrupt output is high while any change flag is set. The second general output gates the UART core's interrupt onto the host interrupt line.

A two-state mode machine sets where the modem inputs come from. In `MODE_EXT` they come from the pins, through a synchronizer. In `MODE_LOOP` they come from the control register bits, and the serial transmit line is turned back into the serial receive line. In that mode the external serial output rests at mark and the external modem outputs are inactive. Each write to the control register is a transition: a write with bit 4 set moves the machine to `MODE_LOOP` (or keeps it there), and a write with bit 4 clear moves it to `MODE_EXT`. Reset enters `MODE_EXT`.

Software reaches the two registers through a one-bit select: 0 is the control register and 1 is the status register. Read data is combinational during the read cycle. The clear that a read causes takes effect at the clock edge that ends that cycle.

Top module: `modem_line_unit`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the four external modem outputs are 0 and both interrupt outputs are 0.
- R2: Control register (select 0): bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback; bits 7..5 read 0. In `MODE_EXT` the external modem outputs equal bits 3..0.
- R3: The host interrupt output equals the UART interrupt input AND control bit 3 (OUT2).
- R4: Status register (select 1) bits 4..7 give the levels of CTS, DSR, RI and DCD. In `MODE_EXT` a pin change shows there SYNC_STAGES+1 clock edges after it is applied.
- R5: Status bits 0..3 are change flags for CTS, DSR, RI and DCD. Each flag is set in the same cycle that its level bit changes, and it stays set until the status register is read.
- R6: A status read clears all four change flags at the edge that ends the read cycle. A level change that lands on that same edge leaves its flag set.
- R7: The modem-status interrupt output is 1 exactly while at least one change flag is 1.
- R8: A write with select 1 has no effect on the status register or on the control register.
- R9: In `MODE_LOOP`, one edge after the control bits take a value, CTS shows RTS, DSR shows DTR, RI shows OUT1 and DCD shows OUT2.
- R10: In `MODE_LOOP`, changes on the external modem inputs do not reach the status register.
- R11: In `MODE_LOOP` the receive line to the core equals the core's transmit line, the external serial output is 1, the external serial input is ignored and the four external modem outputs are 0. In `MODE_EXT` the core's receive line follows the external serial input, and the external serial output follows the core's transmit line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pin_cts | input | 1 | External clear-to-send, active high |
| pin_dsr | input | 1 | External data-set-ready, active high |
| pin_ri | input | 1 | External ring indicator, active high |
| pin_dcd | input | 1 | External carrier detect, active high |
| pin_dtr | output | 1 | External data-terminal-ready, active high |
| pin_rts | output | 1 | External request-to-send, active high |
| pin_out1 | output | 1 | External general output 1 |
| pin_out2 | output | 1 | External general output 2 |
| pin_rxd | input | 1 | External serial input |
| pin_txd | output | 1 | External serial output |
| core_txd | input | 1 | Serial output from the UART transmitter |
| core_rxd | output | 1 | Serial input to the UART receiver |
| uart_irq | input | 1 | Interrupt request from the UART core |
| host_irq | output | 1 | Interrupt to the host, gated by OUT2 |
| msc_irq | output | 1 | Modem-status-change interrupt |

## Verification
The assertions assume that read and write strobes are never asserted together, and that the strobes and the select are synchronous to the clock and free of X after reset. The stimulus meets this by changing every input one time unit after a rising edge, with only one strobe active at a time. The bench holds each external modem input steady for longer than the synchronizer depth, so every change reaches the status register before the next one. The one exception is the check for a change that arrives during a read: there, a single input change is timed so that it lands on the same edge as the read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef enum logic {
        MODE_EXT  = 1'b0,
        MODE_LOOP = 1'b1
    } mode_e;

    // packed so the value lines up with status nibble order
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;
    localparam int CTL_BITS = 5;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) begin
                        stg_q[i] <= stg_q[i-1];
                    end
                end
            end
            assign d_out = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic [7:0]          wr_data,
    output logic [CTL_BITS-1:0] ctrl_q,
    output mode_e               mode_q
);
    mode_e mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_EXT;
            ctrl_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (wr_ctrl) begin
                ctrl_q <= wr_data[CTL_BITS-1:0];
            end
        end
    end

    // transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_EXT: begin
                if (wr_ctrl && wr_data[CTL_LOOP]) mode_d = MODE_LOOP;
            end
            MODE_LOOP: begin
                if (wr_ctrl && !wr_data[CTL_LOOP]) mode_d = MODE_EXT;
            end
            default: mode_d = MODE_EXT;
        endcase
    end

    // R9: every control write leaves the machine in the mode its bit 4 names
    p_mode_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((mode_q == MODE_LOOP) == $past(wr_data[CTL_LOOP])));

    // R2: the control bits only move on a control write
    p_ctrl_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  lines_t src,
    input  logic   rd_stat,
    output lines_t line_q,
    output logic [3:0] delta_q
);
    logic [3:0] change;
    logic [3:0] delta_d;

    assign change = src ^ line_q;

    always_comb begin
        delta_d = rd_stat ? change : (delta_q | change);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            delta_q <= '0;
        end else begin
            line_q  <= src;
            delta_q <= delta_d;
        end
    end

    // R5: flags never drop without a status read
    p_delta_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R6: a read with no concurrent change leaves every flag clear
    p_delta_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (src == line_q)) |=> (delta_q == 4'b0000));
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pin_cts,
    input  logic       pin_dsr,
    input  logic       pin_ri,
    input  logic       pin_dcd,
    output logic       pin_dtr,
    output logic       pin_rts,
    output logic       pin_out1,
    output logic       pin_out2,
    input  logic       pin_rxd,
    output logic       pin_txd,
    input  logic       core_txd,
    output logic       core_rxd,
    input  logic       uart_irq,
    output logic       host_irq,
    output logic       msc_irq
);
    localparam int LINES = 4;

    logic                wr_ctrl;
    logic                rd_stat;
    logic [CTL_BITS-1:0] ctrl_q;
    mode_e               mode_q;
    logic [LINES-1:0]    ext_sync;
    lines_t              ext_lines;
    lines_t              loop_lines;
    lines_t              src;
    lines_t              line_q;
    logic [3:0]          delta_q;

    assign wr_ctrl = wr_en && (reg_sel == 1'b0);
    assign rd_stat = rd_en && (reg_sel == 1'b1);

    mdm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .mode_q  (mode_q)
    );

    mdm_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({pin_dcd, pin_ri, pin_dsr, pin_cts}),
        .d_out (ext_sync)
    );

    assign ext_lines = lines_t'(ext_sync);

    always_comb begin
        loop_lines.cts = ctrl_q[CTL_RTS];
        loop_lines.dsr = ctrl_q[CTL_DTR];
        loop_lines.ri  = ctrl_q[CTL_OUT1];
        loop_lines.dcd = ctrl_q[CTL_OUT2];
    end

    mdm_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .rd_stat (rd_stat),
        .line_q  (line_q),
        .delta_q (delta_q)
    );

    // outputs per mode
    always_comb begin
        unique case (mode_q)
            MODE_EXT: begin
                src      = ext_lines;
                pin_dtr  = ctrl_q[CTL_DTR];
                pin_rts  = ctrl_q[CTL_RTS];
                pin_out1 = ctrl_q[CTL_OUT1];
                pin_out2 = ctrl_q[CTL_OUT2];
                pin_txd  = core_txd;
                core_rxd = pin_rxd;
            end
            MODE_LOOP: begin
                src      = loop_lines;
                pin_dtr  = 1'b0;
                pin_rts  = 1'b0;
                pin_out1 = 1'b0;
                pin_out2 = 1'b0;
                pin_txd  = 1'b1;
                core_rxd = core_txd;
            end
            default: begin
                src      = ext_lines;
                pin_dtr  = 1'b0;
                pin_rts  = 1'b0;
                pin_out1 = 1'b0;
                pin_out2 = 1'b0;
                pin_txd  = 1'b1;
                core_rxd = pin_rxd;
            end
        endcase
    end

    assign host_irq = uart_irq && ctrl_q[CTL_OUT2];
    assign msc_irq  = |delta_q;
    assign rd_data  = reg_sel ? {line_q, delta_q}
                              : {{(8-CTL_BITS){1'b0}}, ctrl_q};

    // R9: in steady loopback the levels mirror the control bits one edge later
    p_loop_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOOP && !wr_ctrl) |=>
            (line_q.cts == $past(ctrl_q[CTL_RTS]) && line_q.dsr == $past(ctrl_q[CTL_DTR]) &&
             line_q.ri  == $past(ctrl_q[CTL_OUT1]) && line_q.dcd == $past(ctrl_q[CTL_OUT2])));

    // R11: loopback keeps the external lines idle
    p_loop_isolate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOOP) |-> (pin_txd && !pin_dtr && !pin_rts && !pin_out1 && !pin_out2));

    // R7: the status interrupt only rises together with a level change
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msc_irq) |-> (line_q != $past(line_q)));
endmodule

// File: tb/modem_line_unit_tb_top.sv
module modem_line_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
    logic       pin_dtr, pin_rts, pin_out1, pin_out2;
    logic       pin_rxd = 1'b1, pin_txd;
    logic       core_txd = 1'b1, core_rxd;
    logic       uart_irq = 1'b0, host_irq, msc_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    modem_line_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_dcd(pin_dcd),
        .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
        .pin_rxd(pin_rxd), .pin_txd(pin_txd), .core_txd(core_txd), .core_rxd(core_rxd),
        .uart_irq(uart_irq), .host_irq(host_irq), .msc_irq(msc_irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare during each read cycle
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check("SCOREBOARD", 8'hEE, 8'h00);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // tasks start and end one unit after a rising edge
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic sel, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_sel = sel; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] pins_out();
        return {4'h0, pin_out2, pin_out1, pin_rts, pin_dtr};
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        check("R1 pins", pins_out(), 8'h00);
        check("R1 irqs", {6'd0, host_irq, msc_irq}, 8'h00);
        rd(0, 8'h00, "R1 ctrl");
        rd(1, 8'h00, "R1 status");
        // R2
        wr(0, 8'hEF);
        rd(0, 8'h0F, "R2 reserved bits");
        check("R2 pins", pins_out(), 8'h0F);
        // R3
        uart_irq = 1'b1; #1;
        check("R3 gate open", {7'd0, host_irq}, 8'h01);
        wr(0, 8'h07);
        check("R3 gate closed", {7'd0, host_irq}, 8'h00);
        check("R2 pins 07", pins_out(), 8'h07);
        // R11 external mode serial path
        core_txd = 1'b0; pin_rxd = 1'b0; #1;
        check("R11 ext path", {6'd0, pin_txd, core_rxd}, 8'h00);
        core_txd = 1'b1; pin_rxd = 1'b1; #1;
        // R4 / R5 / R7
        pin_cts = 1'b1;
        tick(2);
        rd(1, 8'h00, "R4 not yet");
        tick(1);
        check("R7 raised", {7'd0, msc_irq}, 8'h01);
        rd(1, 8'h11, "R5 cts delta");
        check("R7 cleared", {7'd0, msc_irq}, 8'h00);
        rd(1, 8'h10, "R6 cleared");
        pin_dsr = 1'b1; pin_dcd = 1'b1;
        tick(4);
        rd(1, 8'hBA, "R5 dsr dcd");
        rd(1, 8'hB0, "R6 after read");
        // R6 change on the read edge
        pin_ri = 1'b1;
        tick(2);
        rd(1, 8'hB0, "R6 read races change");
        rd(1, 8'hF4, "R6 kept ri delta");
        rd(1, 8'hF0, "R6 clear");
        // R8
        wr(1, 8'hFF);
        rd(1, 8'hF0, "R8 status untouched");
        rd(0, 8'h07, "R8 ctrl untouched");
        // R9 / R11 loopback
        wr(0, 8'h1A);
        tick(1);
        rd(1, 8'h96, "R9 enter loop");
        check("R11 pins idle", pins_out(), 8'h00);
        check("R3 loop gate", {7'd0, host_irq}, 8'h01);
        core_txd = 1'b0; pin_rxd = 1'b1; #1;
        check("R11 loop low", {6'd0, pin_txd, core_rxd}, 8'h02);
        core_txd = 1'b1; pin_rxd = 1'b0; #1;
        check("R11 loop high", {6'd0, pin_txd, core_rxd}, 8'h03);
        pin_rxd = 1'b1;
        // R10
        pin_cts = 1'b0;
        tick(5);
        rd(1, 8'h90, "R10 ext ignored");
        wr(0, 8'h15);
        tick(1);
        rd(1, 8'h6F, "R9 remap");
        // exit loop
        wr(0, 8'h00);
        tick(1);
        rd(1, 8'hE8, "R4 back to pins");
        pin_rxd = 1'b0; core_txd = 1'b1; #1;
        check("R11 exit path", {6'd0, pin_txd, core_rxd}, 8'h02);
        tick(2);
        if (exp_q.size() != 0) check("SCOREBOARD left", 8'(exp_q.size()), 8'h00);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule